// File: doc/BRIEF.md
# Multi-Stage Parallel Trigger Unit

This block watches a 32-channel sample stream and decides when a logic capture should begin. It holds up to four trigger stages. Each stage is programmed with a mask that picks the channels it cares about, a value word, an edge-select word and a config word. The config word carries the stage's level and a start flag. A shared level counter sequences the stages. Only stages whose level equals the counter are evaluated. A match on a stage without the start flag moves the counter up by one. A match on a stage with the start flag emits a single-cycle trigger pulse and disarms the unit.

A command receiver writes the stage registers through a simple write port. Software arms the unit with a pulse. After reset the register set holds the "no trigger" arrangement: stage 0 matches anything and carries the start flag, so capture begins on the first sample after arming. The other stages are parked as disabled, with level 3, mask zero and value zero.

Top module: `trig_stage_unit`

## Requirements
- R1: While reset is high, and after it is released, trig_fire is low until the unit is armed. Reset loads stage 0 with mask 0, value 0, edge 0, level 0 and the start flag set. Stages 1 to 3 get mask 0, value 0, edge 0, level 3 and the start flag clear.
- R2: With cfg_we high, cfg_wdata is written to stage cfg_stage. The target word is chosen by cfg_sel: 0 mask, 1 value, 2 edge select, 3 config. In the config word, bits 17:16 give the level and bit 27 is the start flag. A write takes effect for samples from the next cycle on.
- R3: For a channel with mask bit 1 and edge bit 0, the condition holds when the sample bit equals the value bit.
- R4: For a channel with mask bit 1 and edge bit 1, the value bit picks the edge. Value 1 means rising: the previous valid sample was 0 and the current one is 1. Value 0 means falling: previous 1, current 0.
- R5: Channels with mask bit 0 are ignored. A stage with an all-zero mask matches on every evaluated sample.
- R6: A stage is evaluated only when its level equals the shared level. A match on a stage without the start flag raises the shared level by one, saturating at 3.
- R7: A match on an evaluated stage with the start flag drives trig_fire high for exactly one cycle, in the cycle after the sample. The unit then disarms, and no further pulse occurs until it is armed again.
- R8: A cycle with smp_valid low is not evaluated and does not update the previous-sample register.
- R9: An arm pulse clears the shared level and the previous sample and arms the unit. A sample presented in the same cycle as arm is not evaluated.
- R10: While the unit is not armed, trig_fire stays low and the shared level does not change.
- R11: With the reset register contents, the first valid sample after arming produces the trigger pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Arm pulse; restarts the stage sequence |
| smp_valid | input | 1 | Sample enable strobe |
| smp_data | input | 32 | Sampled channel bus |
| cfg_we | input | 1 | Stage register write strobe |
| cfg_stage | input | 2 | Stage index for the write |
| cfg_sel | input | 2 | Word select: 0 mask, 1 value, 2 edge, 3 config |
| cfg_wdata | input | 32 | Write data |
| trig_fire | output | 1 | One-cycle capture-start pulse |

## Verification
An arm pulse and a sample that would match the active stage can arrive in the same cycle. The bench drives exactly that case: it arms a unit that is already armed, holds the strobe high on a sample that satisfies a start stage, and expects no pulse in that cycle. The pulse must then appear on the following valid sample, because the previous-sample register was cleared. A configuration write that lands in the same cycle as a sample is also provoked, and the sample must be judged against the old register contents. A behavioural model in the bench checks every cycle, including long random runs that mix writes, arms, strobes and four-bit patterns.

// File: rtl/trig_stage_unit.sv
module trig_stage_unit #(
  parameter int NS = 4,
  parameter int W  = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         arm,
  input  logic         smp_valid,
  input  logic [W-1:0] smp_data,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_stage,
  input  logic [1:0]   cfg_sel,
  input  logic [31:0]  cfg_wdata,
  output logic         trig_fire
);
  localparam int LW = (NS > 1) ? $clog2(NS) : 1;
  localparam logic [LW-1:0] TOP_LVL = LW'(NS - 1);

  logic [W-1:0]  msk_q [NS];
  logic [W-1:0]  val_q [NS];
  logic [W-1:0]  edg_q [NS];
  logic [LW-1:0] lvl_q [NS];
  logic [NS-1:0] srt_q;

  logic [W-1:0]  prev_q;
  logic [LW-1:0] cur_lvl;
  logic          armed;

  logic [NS-1:0] hit;
  logic          eval, fire_now, adv_now;

  assign eval = armed & smp_valid & ~arm;

  for (genvar s = 0; s < NS; s++) begin : g_stage
    logic [W-1:0] ok;
    assign ok = ~msk_q[s] |
                (edg_q[s] & ((val_q[s] & ~prev_q & smp_data) | (~val_q[s] & prev_q & ~smp_data))) |
                (~edg_q[s] & ~(smp_data ^ val_q[s]));
    assign hit[s] = eval && (lvl_q[s] == cur_lvl) && (&ok);
  end

  assign fire_now = |(hit & srt_q);
  assign adv_now  = |(hit & ~srt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NS; s++) begin
        msk_q[s] <= '0;
        val_q[s] <= '0;
        edg_q[s] <= '0;
        lvl_q[s] <= (s == 0) ? '0 : TOP_LVL;
        srt_q[s] <= (s == 0);
      end
    end else if (cfg_we && (int'(cfg_stage) < NS)) begin
      case (cfg_sel)
        2'd0: msk_q[cfg_stage] <= cfg_wdata[W-1:0];
        2'd1: val_q[cfg_stage] <= cfg_wdata[W-1:0];
        2'd2: edg_q[cfg_stage] <= cfg_wdata[W-1:0];
        default: begin
          lvl_q[cfg_stage] <= cfg_wdata[16 +: LW];
          srt_q[cfg_stage] <= cfg_wdata[27];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      cur_lvl   <= '0;
      prev_q    <= '0;
      trig_fire <= 1'b0;
    end else begin
      trig_fire <= fire_now;
      if (arm) begin
        armed   <= 1'b1;
        cur_lvl <= '0;
        prev_q  <= '0;
      end else begin
        if (smp_valid) prev_q <= smp_data;
        if (fire_now) armed <= 1'b0;
        else if (adv_now && cur_lvl != TOP_LVL) cur_lvl <= cur_lvl + 1'b1;
      end
    end
  end
endmodule

// File: rtl/trig_stage_chk.sv
module trig_stage_chk #(
  parameter int LW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          arm,
  input logic          smp_valid,
  input logic          trig_fire,
  input logic          armed,
  input logic [LW-1:0] cur_lvl
);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    trig_fire |=> !trig_fire);

  a_r7_disarm: assert property (@(posedge clk) disable iff (rst)
    trig_fire |-> !armed);

  a_r9_arm_clears: assert property (@(posedge clk) disable iff (rst)
    arm |=> (armed && cur_lvl == '0 && !trig_fire));

  a_r8_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> !trig_fire);

  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    (!armed && !arm) |=> (!trig_fire && $stable(cur_lvl)));

  a_r6_level_step: assert property (@(posedge clk) disable iff (rst)
    !arm |=> (cur_lvl == $past(cur_lvl) ||
              {1'b0, cur_lvl} == {1'b0, $past(cur_lvl)} + 1'b1));
endmodule

bind trig_stage_unit trig_stage_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst(rst), .arm(arm), .smp_valid(smp_valid),
  .trig_fire(trig_fire), .armed(armed), .cur_lvl(cur_lvl)
);

// File: tb/tb_trig_stage_unit.sv
module tb_trig_stage_unit;
  logic        clk = 0;
  logic        rst, arm, smp_valid, cfg_we;
  logic [31:0] smp_data, cfg_wdata;
  logic [1:0]  cfg_stage, cfg_sel;
  logic        trig_fire;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_msk [4];
  logic [31:0] m_val [4];
  logic [31:0] m_edg [4];
  int          m_lvl [4];
  bit          m_srt [4];
  int          lvl;
  bit          armd;
  logic [31:0] prev;
  bit          exp_fire;

  always #2 clk = ~clk;

  trig_stage_unit dut (
    .clk(clk), .rst(rst), .arm(arm), .smp_valid(smp_valid), .smp_data(smp_data),
    .cfg_we(cfg_we), .cfg_stage(cfg_stage), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .trig_fire(trig_fire)
  );

  task automatic model_reset();
    for (int s = 0; s < 4; s++) begin
      m_msk[s] = 0; m_val[s] = 0; m_edg[s] = 0;
      m_lvl[s] = (s == 0) ? 0 : 3;
      m_srt[s] = (s == 0);
    end
    lvl = 0; armd = 0; prev = 0; exp_fire = 0;
  endtask

  function automatic bit stage_ok(int s, logic [31:0] d);
    for (int b = 0; b < 32; b++) begin
      if (m_msk[s][b]) begin
        if (m_edg[s][b]) begin
          if (m_val[s][b] && !(prev[b] == 0 && d[b] == 1)) return 0;
          if (!m_val[s][b] && !(prev[b] == 1 && d[b] == 0)) return 0;
        end else if (d[b] != m_val[s][b]) return 0;
      end
    end
    return 1;
  endfunction

  function automatic logic [31:0] cw(int l, bit st);
    return (32'(l) << 16) | (32'(st) << 27);
  endfunction

  task automatic check(string tag);
    checks++;
    if (trig_fire !== exp_fire) begin
      errors++;
      $display("FAIL %s: trig_fire=%0b expected=%0b at %0t", tag, trig_fire, exp_fire, $time);
    end
  endtask

  task automatic step(bit a, bit v, logic [31:0] d, bit we, int st, int sel, logic [31:0] wd, string tag);
    bit f, ad;
    arm = a; smp_valid = v; smp_data = d;
    cfg_we = we; cfg_stage = 2'(st); cfg_sel = 2'(sel); cfg_wdata = wd;
    @(posedge clk);
    f = 0; ad = 0;
    if (!a && armd && v)
      for (int s = 0; s < 4; s++)
        if (m_lvl[s] == lvl && stage_ok(s, d)) begin
          if (m_srt[s]) f = 1; else ad = 1;
        end
    if (a) begin armd = 1; lvl = 0; prev = 0; end
    else begin
      if (v) prev = d;
      if (f) armd = 0;
      else if (ad && lvl < 3) lvl++;
    end
    if (we) case (sel)
      0: m_msk[st] = wd;
      1: m_val[st] = wd;
      2: m_edg[st] = wd;
      default: begin m_lvl[st] = int'(wd[17:16]); m_srt[st] = wd[27]; end
    endcase
    exp_fire = f;
    #1 check(tag);
    @(negedge clk);
  endtask

  task automatic cfg(int st, int sel, logic [31:0] wd);
    step(0, 0, 0, 1, st, sel, wd, "R2");
  endtask

  task automatic smp(logic [31:0] d, string tag);
    step(0, 1, d, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; arm = 0; smp_valid = 0; smp_data = 0;
    cfg_we = 0; cfg_stage = 0; cfg_sel = 0; cfg_wdata = 0;
    model_reset();
    repeat (3) @(negedge clk);
    checks++;
    if (trig_fire !== 1'b0) begin errors++; $display("FAIL R1: trig_fire=%0b expected=0 in reset", trig_fire); end
    rst = 0;
    @(negedge clk);
    smp(32'hFFFF_FFFF, "R10");
    smp(32'h0, "R1");

    // R11 / R5: reset contents fire on first valid sample after arm
    step(1, 0, 0, 0, 0, 0, 0, "R9");
    smp(32'h1234_5678, "R11");
    smp(32'h1234_5678, "R7");
    smp(32'h0, "R7");

    // R3 + R6 + R4: stage0 level match advances, stage1 rising edge on bit 8 starts
    cfg(0, 0, 32'h0000_00FF); cfg(0, 1, 32'h0000_00A5); cfg(0, 2, 0); cfg(0, 3, cw(0, 0));
    cfg(1, 0, 32'h0000_0100); cfg(1, 1, 32'h0000_0100); cfg(1, 2, 32'h0000_0100); cfg(1, 3, cw(1, 1));
    step(1, 0, 0, 0, 0, 0, 0, "R9");
    smp(32'h0000_0100, "R6");
    smp(32'h0000_00A4, "R3");
    smp(32'hFF00_00A5, "R5");
    smp(32'h0000_0000, "R6");
    step(0, 0, 32'h0000_0100, 0, 0, 0, 0, "R8");
    smp(32'h0000_0100, "R4");
    smp(32'h0000_0000, "R7");

    // falling edge at level 2, stage 2
    cfg(1, 3, cw(1, 0));
    cfg(2, 0, 32'h8000_0000); cfg(2, 1, 0); cfg(2, 2, 32'h8000_0000); cfg(2, 3, cw(2, 1));
    step(1, 0, 0, 0, 0, 0, 0, "R9");
    smp(32'h0000_00A5, "R6");
    smp(32'h0000_0100, "R6");
    smp(32'h0000_0000, "R4");
    smp(32'h8000_0000, "R4");
    smp(32'h0000_0000, "R4");

    // R9: arm coincides with a matching sample
    cfg(0, 0, 0); cfg(0, 3, cw(0, 1));
    step(1, 0, 0, 0, 0, 0, 0, "R9");
    step(1, 1, 32'hDEAD_BEEF, 0, 0, 0, 0, "R9");
    smp(32'hDEAD_BEEF, "R9");
    // config write in same cycle as a sample: old contents judge it
    cfg(0, 0, 32'h1); cfg(0, 1, 32'h1); cfg(0, 3, cw(0, 0));
    step(1, 0, 0, 0, 0, 0, 0, "R9");
    step(0, 1, 32'h1, 1, 0, 3, cw(0, 1), "R2");
    smp(32'h1, "R2");

    // saturation at level 3 with disabled stages
    for (int s = 0; s < 4; s++) begin cfg(s, 0, 0); cfg(s, 1, 0); cfg(s, 2, 0); cfg(s, 3, cw(s, 0)); end
    step(1, 0, 0, 0, 0, 0, 0, "R9");
    for (int i = 0; i < 6; i++) smp(32'(i), "R6");
    cfg(3, 3, cw(3, 1));
    smp(32'h0, "R6");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 8) step(0, 0, 0, 1, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                      ($urandom_range(0, 3) == 3) ? cw(int'($urandom_range(0, 3)), 1'($urandom)) : 32'($urandom_range(0, 15)),
                      "R6");
      else if (r < 12) step(1, 1'($urandom), 32'($urandom_range(0, 15)), 0, 0, 0, 0, "R9");
      else step(0, ($urandom_range(0, 3) != 0), 32'($urandom_range(0, 15)), 0, 0, 0, 0, "R3");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule